// File: doc/BRIEF.md
# Firmware Image Integrity Checker

This block runs at boot, before any application code is allowed to execute. On a start pulse it clears an external CRC unit, then reads a memory-mapped firmware region one 32-bit word at a time, from a base address up to an end address (the end itself is not read). Each word it reads goes to the CRC unit over a simple clear/data/valid stream. When the whole region has been fed, the block decides whether the image is genuine. It raises `boot_en_o` to release the application only when it accepts the image. Otherwise it stays in a failed state and leaves control with the bootloader.

The block has two acceptance modes, chosen by `residue_mode_i` when the run starts. In stored-value mode, one word at a configurable address inside the image holds the expected CRC. That word is left out of the computation. After the scan the block reads it again and compares it with the CRC unit's result. In residue mode, every word of the region is fed, including the appended check word. The image is accepted when the final CRC value equals a fixed residue parameter.

Unprogrammed locations in the region read back as all ones. They take part in the computation like any other word. The memory port accepts any read latency of one cycle or more.

Top module: `fw_integrity_checker`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `image_ok_o`, `boot_en_o`, `mem_rd_o`, `crc_clr_o` and `crc_valid_o` are all low.
- R2: A `start_i` pulse seen while the block is not busy does three things. It produces exactly one `crc_clr_o` cycle in the next cycle, before any `crc_valid_o`. It drives `busy_o` high from that next cycle onward. It drops `image_ok_o` and `boot_en_o` in that same cycle.
- R3: Region words are read in ascending order, from `BASE_ADDR` to `END_ADDR`-4 in steps of 4. Each read is a one-cycle `mem_rd_o` strobe. No new strobe is issued until `mem_rvalid_i` has returned the previous word, which arrives at least one cycle after its strobe.
- R4: In stored-value mode (`residue_mode_i`=0 at start), every region word except the one at `EXP_ADDR` is presented on `crc_data_o` with `crc_valid_o`, in address order and unchanged.
- R5: In stored-value mode, after the scan the block reads `EXP_ADDR` once more. It accepts the image only if `crc_result_i` equals that word.
- R6: In residue mode (`residue_mode_i`=1 at start), every region word, the check word included, is fed in order. The block accepts the image only if `crc_result_i` equals `RESIDUE`.
- R7: `crc_result_i` is sampled no earlier than the cycle after the last `crc_valid_o`, so the CRC unit may take one cycle to register its result.
- R8: `done_o` pulses for exactly one cycle, in the first cycle of the verdict. `busy_o` is low in that cycle.
- R9: After an accepted image, `image_ok_o` and `boot_en_o` stay high until the next start. After a rejected image, both stay low.
- R10: A `start_i` pulse seen while the block is busy is ignored. The run is not restarted, there is no extra clear, and only one `done_o` pulse occurs.
- R11: Words that read as all ones (unprogrammed flash) are fed and checked like any other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a check run |
| residue_mode_i | input | 1 | Acceptance mode captured at start: 0 = stored value, 1 = residue |
| mem_addr_o | output | ADDR_W | Byte address of the word being read |
| mem_rd_o | output | 1 | One-cycle read strobe |
| mem_rdata_i | input | DATA_W | Read data |
| mem_rvalid_i | input | 1 | Read data valid |
| crc_clr_o | output | 1 | Reset the CRC unit to its initial value |
| crc_data_o | output | DATA_W | Word for the CRC unit |
| crc_valid_o | output | 1 | `crc_data_o` is valid |
| crc_result_i | input | DATA_W | Current CRC value from the unit |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when the verdict is reached |
| image_ok_o | output | 1 | The image was accepted |
| boot_en_o | output | 1 | Release the application |

## Verification
The hardest case to reach from the ports is a stored-value run in which the check word is skipped while feeding and then read again afterward. The corrupted run must also fail in both modes, not only in one. The bench gives the region a CRC-32 check word as its last word, so the same image is valid in both modes, with a residue of zero. It then flips a single data word to produce the failures. A bench CRC unit records every word fed and every address read, so the skip, the extra fetch and the strict one-read-at-a-time behaviour can be compared word by word against memory latencies of one to four cycles. A start pulse issued mid-scan and a run over a mostly erased region cover the ignored-start case and the all-ones case.

// File: rtl/fic_pkg.sv
`timescale 1ns/1ps
package fic_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_READ,
        ST_FEED,
        ST_FETCH_EXP,
        ST_COMPARE,
        ST_PASS,
        ST_FAIL
    } fic_state_e;

    function automatic logic is_active(input fic_state_e st);
        return !(st == ST_IDLE || st == ST_PASS || st == ST_FAIL);
    endfunction

endpackage

// File: rtl/fic_range_decode.sv
`timescale 1ns/1ps
module fic_range_decode #(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] END_ADDR   = 32'h0802_0000,
    parameter logic [ADDR_W-1:0] EXP_ADDR   = 32'h0801_FFFC,
    parameter int                WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              at_last_o,
    output logic              at_exp_o,
    output logic [ADDR_W-1:0] next_addr_o
);
    localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] LAST_ADDR = END_ADDR - STEP;

    assign at_last_o   = (addr_i == LAST_ADDR);
    assign at_exp_o    = (addr_i == EXP_ADDR);
    assign next_addr_o = addr_i + STEP;
endmodule

// File: rtl/fic_verdict.sv
`timescale 1ns/1ps
module fic_verdict #(
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] RESIDUE = '0
) (
    input  logic              residue_mode_i,
    input  logic [DATA_W-1:0] crc_i,
    input  logic [DATA_W-1:0] stored_i,
    output logic              accept_o
);
    logic match_stored;
    logic match_residue;

    assign match_stored  = (crc_i == stored_i);
    assign match_residue = (crc_i == RESIDUE);
    assign accept_o      = residue_mode_i ? match_residue : match_stored;
endmodule

// File: rtl/fw_integrity_checker.sv
`timescale 1ns/1ps
module fw_integrity_checker
    import fic_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0800_0000,
    parameter logic [ADDR_W-1:0] END_ADDR  = 32'h0802_0000,
    parameter logic [ADDR_W-1:0] EXP_ADDR  = 32'h0801_FFFC,
    parameter logic [DATA_W-1:0] RESIDUE   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              residue_mode_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_rvalid_i,
    output logic              crc_clr_o,
    output logic [DATA_W-1:0] crc_data_o,
    output logic              crc_valid_o,
    input  logic [DATA_W-1:0] crc_result_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              image_ok_o,
    output logic              boot_en_o
);
    localparam int WORD_BYTES = DATA_W / 8;

    typedef struct packed {
        fic_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              res_mode;
        logic [DATA_W-1:0] stored;
        logic              req;
        logic              done;
        logic              ok;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              at_last, at_exp, accept;
    logic [ADDR_W-1:0] next_addr;
    logic              rd_c, clr_c, vld_c;

    fic_range_decode #(
        .ADDR_W    (ADDR_W),
        .END_ADDR  (END_ADDR),
        .EXP_ADDR  (EXP_ADDR),
        .WORD_BYTES(WORD_BYTES)
    ) i_range (
        .addr_i     (ctl_q.addr),
        .at_last_o  (at_last),
        .at_exp_o   (at_exp),
        .next_addr_o(next_addr)
    );

    fic_verdict #(
        .DATA_W (DATA_W),
        .RESIDUE(RESIDUE)
    ) i_verdict (
        .residue_mode_i(ctl_q.res_mode),
        .crc_i         (crc_result_i),
        .stored_i      (ctl_q.stored),
        .accept_o      (accept)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        rd_c       = 1'b0;
        clr_c      = 1'b0;
        vld_c      = 1'b0;
        case (ctl_q.st)
            ST_IDLE, ST_PASS, ST_FAIL: begin
                if (start_i) begin
                    ctl_d.st       = ST_CLEAR;
                    ctl_d.res_mode = residue_mode_i;
                    ctl_d.ok       = 1'b0;
                end
            end
            ST_CLEAR: begin
                clr_c      = 1'b1;
                ctl_d.addr = BASE_ADDR;
                ctl_d.st   = ST_READ;
            end
            ST_READ: begin
                rd_c     = 1'b1;
                ctl_d.st = ST_FEED;
            end
            ST_FEED: begin
                if (mem_rvalid_i) begin
                    // stored-value mode leaves the check word out of the sum
                    vld_c = ctl_q.res_mode || !at_exp;
                    if (at_last) begin
                        ctl_d.req = 1'b0;
                        ctl_d.st  = ctl_q.res_mode ? ST_COMPARE : ST_FETCH_EXP;
                    end else begin
                        ctl_d.addr = next_addr;
                        ctl_d.st   = ST_READ;
                    end
                end
            end
            ST_FETCH_EXP: begin
                if (!ctl_q.req) begin
                    rd_c      = 1'b1;
                    ctl_d.req = 1'b1;
                end else if (mem_rvalid_i) begin
                    ctl_d.stored = mem_rdata_i;
                    ctl_d.st     = ST_COMPARE;
                end
            end
            ST_COMPARE: begin
                ctl_d.ok   = accept;
                ctl_d.done = 1'b1;
                ctl_d.st   = accept ? ST_PASS : ST_FAIL;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, addr: BASE_ADDR, res_mode: 1'b0,
                       stored: '0, req: 1'b0, done: 1'b0, ok: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_addr_o  = (ctl_q.st == ST_FETCH_EXP) ? EXP_ADDR : ctl_q.addr;
    assign mem_rd_o    = rd_c;
    assign crc_clr_o   = clr_c;
    assign crc_data_o  = mem_rdata_i;
    assign crc_valid_o = vld_c;
    assign busy_o      = is_active(ctl_q.st);
    assign done_o      = ctl_q.done;
    assign image_ok_o  = ctl_q.ok;
    assign boot_en_o   = (ctl_q.st == ST_PASS);
endmodule

// File: rtl/fic_checker.sv
`timescale 1ns/1ps
module fic_checker (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic mem_rd_o,
    input logic mem_rvalid_i,
    input logic crc_clr_o,
    input logic crc_valid_o,
    input logic busy_o,
    input logic done_o,
    input logic image_ok_o,
    input logic boot_en_o
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pend_q <= 1'b0;
        else if (mem_rd_o)     pend_q <= 1'b1;
        else if (mem_rvalid_i) pend_q <= 1'b0;
    end

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o);

    a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> !pend_q);

    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (crc_clr_o && busy_o));

    a_r4_feed_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        crc_valid_o |-> busy_o);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r9_ok_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (image_ok_o && !start_i) |=> image_ok_o);

    a_r9_boot_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        boot_en_o |-> !busy_o);

    a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !crc_clr_o);
endmodule

bind fw_integrity_checker fic_checker i_fic_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mem_rd_o    (mem_rd_o),
    .mem_rvalid_i(mem_rvalid_i),
    .crc_clr_o   (crc_clr_o),
    .crc_valid_o (crc_valid_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .image_ok_o  (image_ok_o),
    .boot_en_o   (boot_en_o)
);

// File: tb/test_fw_integrity_checker.sv
`timescale 1ns/1ps
module test_fw_integrity_checker;
    localparam int          NW    = 16;
    localparam logic [31:0] BASE  = 32'h0000_1000;
    localparam logic [31:0] ENDA  = BASE + 32'(NW * 4);
    localparam logic [31:0] EXPA  = ENDA - 32'd4;
    localparam logic [31:0] POLY  = 32'h04C1_1DB7;
    localparam int          LOGSZ = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rmode = 1'b0;
    logic [31:0] mem_addr;
    logic        mem_rd;
    logic [31:0] rdata = '0;
    logic        rvalid = 1'b0;
    logic        crc_clr;
    logic [31:0] crc_data;
    logic        crc_valid;
    logic [31:0] crc_q = 32'hFFFF_FFFF;
    logic        busy, done, image_ok, boot_en;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [NW];
    int          lat = 1;

    fw_integrity_checker #(
        .ADDR_W(32), .DATA_W(32),
        .BASE_ADDR(BASE), .END_ADDR(ENDA), .EXP_ADDR(EXPA), .RESIDUE(32'h0)
    ) i_fw_integrity_checker (
        .clk(clk), .rst_n(rst_n), .start_i(start), .residue_mode_i(rmode),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_rdata_i(rdata),
        .mem_rvalid_i(rvalid), .crc_clr_o(crc_clr), .crc_data_o(crc_data),
        .crc_valid_o(crc_valid), .crc_result_i(crc_q), .busy_o(busy),
        .done_o(done), .image_ok_o(image_ok), .boot_en_o(boot_en)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] crc_step(input logic [31:0] r, input logic [31:0] w);
        logic [31:0] x = r ^ w;
        for (int b = 0; b < 32; b++) x = x[31] ? ((x << 1) ^ POLY) : (x << 1);
        return x;
    endfunction

    function automatic logic [31:0] word_at(input logic [31:0] a);
        if (a >= BASE && a < ENDA) return mem[(a - BASE) >> 2];
        return 32'hFFFF_FFFF;
    endfunction

    // bench CRC unit: registered result
    always @(posedge clk) begin
        if (crc_clr)        crc_q <= 32'hFFFF_FFFF;
        else if (crc_valid) crc_q <= crc_step(crc_q, crc_data);
    end

    // memory with programmable latency, driven away from the active edge
    logic        pend = 1'b0;
    int          cnt = 0;
    logic [31:0] paddr = '0;
    int          overlap = 0;
    always @(negedge clk) begin
        rvalid <= 1'b0;
        if (mem_rd && pend) overlap++;
        if (pend) begin
            if (cnt <= 1) begin
                rvalid <= 1'b1;
                rdata  <= word_at(paddr);
                pend   <= 1'b0;
            end else cnt <= cnt - 1;
        end
        if (mem_rd) begin
            pend  <= 1'b1;
            cnt   <= lat;
            paddr <= mem_addr;
        end
    end

    // activity log
    logic [31:0] fed_log [LOGSZ];
    logic [31:0] rd_log  [LOGSZ];
    int fed_n = 0, rd_n = 0, clr_n = 0, done_n = 0, early = 0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (crc_clr) clr_n++;
            if (crc_valid) begin
                if (crc_clr) early++;
                fed_log[fed_n % LOGSZ] = crc_data;
                fed_n++;
            end
            if (mem_rd) begin
                rd_log[rd_n % LOGSZ] = mem_addr;
                rd_n++;
            end
            if (done) done_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic good_image(input logic [31:0] seed);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int i = 0; i < NW - 1; i++) begin
            mem[i] = seed ^ (32'h9E37_79B9 * 32'(i + 1));
            r = crc_step(r, mem[i]);
        end
        mem[NW-1] = r;
    endtask

    task automatic run_image(input bit resm, input int latency, input bit exp_pass,
                             input bit poke, input string tag);
        int s_fed, s_rd, s_clr, s_done, s_early, s_ovl, cyc, bad, nfeed, nrd, j;
        string vreq;
        vreq  = resm ? "R6" : "R5";
        lat   = latency;
        s_fed = fed_n; s_rd = rd_n; s_clr = clr_n; s_done = done_n;
        s_early = early; s_ovl = overlap;
        @(negedge clk); start = 1'b1; rmode = resm;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R2", {tag, " busy after start"}, 32'(busy), 1);
        chk(boot_en == 1'b0 && image_ok == 1'b0, "R9",
            {tag, " verdict cleared on start"}, {30'd0, boot_en, image_ok}, 0);
        if (poke) begin
            repeat (6) @(negedge clk);
            start = 1'b1; rmode = ~resm;
            @(negedge clk); start = 1'b0;
            chk(busy == 1'b1, "R10", {tag, " still busy after ignored start"}, 32'(busy), 1);
        end
        cyc = 0;
        while (!done && cyc < 4000) begin @(negedge clk); cyc++; end
        chk(done == 1'b1, "R8", {tag, " done reached"}, 32'(done), 1);
        if (!done) return;
        chk(busy == 1'b0, "R8", {tag, " busy low with done"}, 32'(busy), 0);
        chk(image_ok == exp_pass, vreq, {tag, " image_ok"}, 32'(image_ok), 32'(exp_pass));
        chk(boot_en == exp_pass, "R9", {tag, " boot_en"}, 32'(boot_en), 32'(exp_pass));
        @(negedge clk);
        chk(done == 1'b0, "R8", {tag, " done one cycle"}, 32'(done), 0);
        chk(done_n - s_done == 1, "R10", {tag, " done count"}, 32'(done_n - s_done), 1);
        chk(clr_n - s_clr == 1, "R2", {tag, " clear count"}, 32'(clr_n - s_clr), 1);
        chk(early == s_early, "R2", {tag, " no feed with clear"}, 32'(early - s_early), 0);
        // feed stream (R4 skips the check word, R6 keeps it, R11 ones included)
        nfeed = resm ? NW : NW - 1;
        chk(fed_n - s_fed == nfeed, resm ? "R6" : "R4", {tag, " fed word count"},
            32'(fed_n - s_fed), 32'(nfeed));
        bad = 0;
        for (int i = 0; i < nfeed && i < fed_n - s_fed; i++)
            if (fed_log[(s_fed + i) % LOGSZ] !== mem[i]) bad++;
        chk(bad == 0, resm ? "R6" : "R4", {tag, " fed words match memory"}, 32'(bad), 0);
        // read sequence
        nrd = resm ? NW : NW + 1;
        chk(rd_n - s_rd == nrd, "R3", {tag, " read count"}, 32'(rd_n - s_rd), 32'(nrd));
        bad = 0;
        for (int i = 0; i < nrd && i < rd_n - s_rd; i++) begin
            j = i;
            if (rd_log[(s_rd + i) % LOGSZ] !== ((j < NW) ? BASE + 32'(4 * j) : EXPA)) bad++;
        end
        chk(bad == 0, resm ? "R3" : "R5", {tag, " read addresses"}, 32'(bad), 0);
        chk(overlap == s_ovl, "R3", {tag, " one read outstanding"}, 32'(overlap - s_ovl), 0);
        repeat (12) @(negedge clk);
        chk(boot_en == exp_pass && image_ok == exp_pass, "R9", {tag, " verdict held"},
            {30'd0, boot_en, image_ok}, {30'd0, exp_pass, exp_pass});
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk({busy, done, image_ok, boot_en, mem_rd, crc_clr, crc_valid} == 7'b0, "R1",
            "reset outputs", {25'd0, busy, done, image_ok, boot_en, mem_rd, crc_clr, crc_valid}, 0);
    endtask

    task automatic t_cmp_pass;   good_image(32'h1234_5678); run_image(1'b0, 1, 1'b1, 1'b0, "cmp_pass"); endtask
    task automatic t_res_pass;   run_image(1'b1, 4, 1'b1, 1'b0, "res_pass R7"); endtask
    task automatic t_cmp_fail;   mem[5] = mem[5] ^ 32'h0000_0100; run_image(1'b0, 2, 1'b0, 1'b0, "cmp_fail"); endtask
    task automatic t_res_fail;   run_image(1'b1, 1, 1'b0, 1'b0, "res_fail"); endtask
    task automatic t_erased;
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int i = 0; i < NW; i++) mem[i] = 32'hFFFF_FFFF;
        mem[0] = 32'h2000_4000; mem[1] = 32'h0800_0101; mem[2] = 32'hDEAD_BEEF;
        for (int i = 0; i < NW - 1; i++) r = crc_step(r, mem[i]);
        mem[NW-1] = r;
        run_image(1'b0, 3, 1'b1, 1'b0, "erased R11");
        run_image(1'b1, 2, 1'b1, 1'b0, "erased_res R11");
    endtask
    task automatic t_busy_start; good_image(32'hA5A5_0F0F); run_image(1'b0, 2, 1'b1, 1'b1, "busy_start"); endtask
    task automatic t_restart;    run_image(1'b1, 1, 1'b1, 1'b1, "restart"); endtask

    initial begin : wdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) mem[i] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_cmp_pass();
        t_res_pass();
        t_cmp_fail();
        t_res_fail();
        t_erased();
        t_busy_start();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule